// File: doc/BRIEF.md
# Cascade Data Segment Extractor

This block sits behind the header decoder of one node in a daisy-chained LED driver. Once the decoder reports a good header, it takes the command code and the multiplex setting. The block then removes this node's share from the front of the serial data segment and loads that share into the node's registers. Every bit after the share, including a trailing tail of any length, is copied to the serial output one clock later. The next node in the chain therefore sees a data segment that is shorter by exactly this node's share.

The size of the share depends on the command. A colour-trim load takes three different bytes. An intensity load or a configuration load takes one byte that is sent three times, and the block keeps the bitwise majority of the three copies. A pulse-width load takes 24 values of PW bits, or 48 values when multiplexing is on. Nothing is written until the whole share has arrived. The targets are then updated together, one cycle after the last bit of the share.

Top module: `cascade_share_taker`

## Requirements
- R1: While rst_n is low, dout and every register output are zero.
- R2: While frame_en is low, the block is idle: dout is zero on the next cycle, hdr_valid is ignored, and a partly received share is dropped without updating any register.
- R3: A cycle with hdr_valid and frame_en both high starts a share, and the share begins with the following bit. hdr_cmd and mux_en are sampled in that same cycle. The share is 24 bits for hdr_cmd 01, 10 and 11. For hdr_cmd 00 it is 24*PW bits with mux_en low, or 48*PW bits with mux_en high. dout stays zero while the share is being taken.
- R4: After the share, each din bit sampled while frame_en is high appears on dout one cycle later, for any number of bits.
- R5: hdr_cmd 01 loads colour-trim bytes in arrival order. The first byte goes to cal_b, the second to cal_g and the third to cal_r, and each byte is sent MSB first.
- R6: hdr_cmd 10 loads gint and hdr_cmd 11 loads cfg. Each holds the bitwise majority of three MSB-first byte copies, and no other register changes.
- R7: hdr_cmd 00 with mux_en low loads pwm0 only. Slot s = color*8 + index sits at pwm0[s*PW +: PW], with color B=0, G=1, R=2. Values arrive as B7..B0, then G7..G0, then R7..R0, each MSB first. pwm1 is unchanged.
- R8: hdr_cmd 00 with mux_en high sends, for each output in the same order, its phase-0 value and then its phase-1 value. These go to pwm0 and pwm1, which use the same slot layout.
- R9: Registers change only at the clock edge one cycle after the last share bit is sampled. They are never written from a partial share.
- R10: hdr_valid while a share is being taken restarts the share with the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_en | input | 1 | High while a frame is in progress |
| hdr_valid | input | 1 | One-cycle pulse: a header was accepted |
| hdr_cmd | input | 2 | Decoded command |
| mux_en | input | 1 | Multiplexed pulse-width payload |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data to the next node |
| cal_b | output | 8 | Blue colour-trim value |
| cal_g | output | 8 | Green colour-trim value |
| cal_r | output | 8 | Red colour-trim value |
| gint | output | 8 | Global intensity value |
| cfg | output | 8 | Configuration value |
| pwm0 | output | 24*PW | Phase-0 pulse-width values |
| pwm1 | output | 24*PW | Phase-1 pulse-width values |

## Verification
The assertions check on every cycle that the output stays silent while idle or taking a share, and that it copies the input with a one-cycle delay once the share has been taken. They also check that the commit strobe lasts one cycle and fires only on entry to pass-through, and that registers hold in every cycle without a commit. The bench scenarios are needed for the rest: the length of each share, the byte order and slot mapping, the majority vote over deliberately corrupted copies, the abort when frame_en drops, and the restart.

// File: rtl/cascade_share_taker.sv
module cascade_share_taker #(
  parameter int PW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_en,
  input  logic             hdr_valid,
  input  logic [1:0]       hdr_cmd,
  input  logic             mux_en,
  input  logic             din,
  output logic             dout,
  output logic [7:0]       cal_b,
  output logic [7:0]       cal_g,
  output logic [7:0]       cal_r,
  output logic [7:0]       gint,
  output logic [7:0]       cfg,
  output logic [24*PW-1:0] pwm0,
  output logic [24*PW-1:0] pwm1
);
  localparam int SRL = 48 * PW;
  localparam int CW  = $clog2(SRL + 1);
  localparam logic [1:0] C_PWM = 2'b00, C_CAL = 2'b01, C_GINT = 2'b10, C_CFG = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_TAKE, S_PASS} st_t;

  st_t            st;
  logic [CW-1:0]  rem, need;
  logic [1:0]     cmd_q;
  logic           mux_q, done_q;
  logic [SRL-1:0] sr;
  logic [7:0]     vote;

  always_comb begin
    case (hdr_cmd)
      C_PWM:   need = mux_en ? CW'(48 * PW) : CW'(24 * PW);
      default: need = CW'(24);
    endcase
  end

  assign vote = (sr[23:16] & sr[15:8]) | (sr[23:16] & sr[7:0]) | (sr[15:8] & sr[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      cmd_q  <= '0;
      mux_q  <= 1'b0;
      done_q <= 1'b0;
      dout   <= 1'b0;
      sr     <= '0;
    end else begin
      dout   <= (st == S_PASS && frame_en) ? din : 1'b0;
      done_q <= 1'b0;
      if (!frame_en) begin
        st <= S_IDLE;
      end else if (hdr_valid) begin
        st    <= S_TAKE;
        rem   <= need;
        cmd_q <= hdr_cmd;
        mux_q <= mux_en;
      end else if (st == S_TAKE) begin
        sr  <= {sr[SRL-2:0], din};
        rem <= rem - CW'(1);
        if (rem == CW'(1)) begin
          st     <= S_PASS;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_b <= '0;
      cal_g <= '0;
      cal_r <= '0;
      gint  <= '0;
      cfg   <= '0;
    end else if (done_q) begin
      case (cmd_q)
        C_CAL: begin
          cal_b <= sr[23:16];
          cal_g <= sr[15:8];
          cal_r <= sr[7:0];
        end
        C_GINT:  gint <= vote;
        C_CFG:   cfg  <= vote;
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < 24; s++) begin : g_slot
    localparam int J = (s / 8) * 8 + 7 - (s % 8);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pwm0[s*PW +: PW] <= '0;
        pwm1[s*PW +: PW] <= '0;
      end else if (done_q && cmd_q == C_PWM) begin
        if (mux_q) begin
          pwm0[s*PW +: PW] <= sr[(47 - 2*J)*PW +: PW];
          pwm1[s*PW +: PW] <= sr[(46 - 2*J)*PW +: PW];
        end else begin
          pwm0[s*PW +: PW] <= sr[(23 - J)*PW +: PW];
        end
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_en |=> !dout);
  p_take_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAKE) |=> !dout);
  p_pass_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PASS && frame_en) |=> dout == $past(din));
  p_commit_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st == S_PASS && !$past(done_q)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |=> ($stable(cal_b) && $stable(cal_g) && $stable(cal_r) &&
                 $stable(gint) && $stable(cfg) && $stable(pwm0) && $stable(pwm1)));
endmodule

// File: tb/cascade_share_taker_test.sv
module cascade_share_taker_test;
  localparam int PW  = 12;
  localparam int TCK = 10;

  logic clk = 1'b0, rst_n = 1'b0, frame_en = 1'b0, hdr_valid = 1'b0, mux_en = 1'b0, din = 1'b0;
  logic [1:0] hdr_cmd = 2'b00;
  logic dout;
  logic [7:0] cal_b, cal_g, cal_r, gint, cfg;
  logic [24*PW-1:0] pwm0, pwm1;

  always #(TCK/2) clk = ~clk;

  cascade_share_taker #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .hdr_valid(hdr_valid),
    .hdr_cmd(hdr_cmd), .mux_en(mux_en), .din(din), .dout(dout),
    .cal_b(cal_b), .cal_g(cal_g), .cal_r(cal_r), .gint(gint), .cfg(cfg),
    .pwm0(pwm0), .pwm1(pwm1));

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  int md = 0, rem = 0, cq = 0, mq = 0;
  bit q[$];
  bit pend = 0, e_dout = 0;
  int e_cb = 0, e_cg = 0, e_cr = 0, e_gi = 0, e_cf = 0;
  int ep0[24], ep1[24];
  string dtag = "R1";

  function automatic int need_of(int c, int m);
    if (c != 0) return 24;
    return m ? 48 * PW : 24 * PW;
  endfunction

  function automatic int val_at(int start, int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | int'(q[start + i]);
    return v;
  endfunction

  function automatic int maj3(int a, int b, int c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic model_commit();
    if (cq == 1) begin
      e_cb = val_at(0, 8); e_cg = val_at(8, 8); e_cr = val_at(16, 8);
    end else if (cq == 2) begin
      e_gi = maj3(val_at(0, 8), val_at(8, 8), val_at(16, 8));
    end else if (cq == 3) begin
      e_cf = maj3(val_at(0, 8), val_at(8, 8), val_at(16, 8));
    end else begin
      for (int j = 0; j < 24; j++) begin
        int slot = (j / 8) * 8 + 7 - (j % 8);
        if (mq) begin
          ep0[slot] = val_at(2 * j * PW, PW);
          ep1[slot] = val_at((2 * j + 1) * PW, PW);
        end else begin
          ep0[slot] = val_at(j * PW, PW);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      md = 0; rem = 0; pend = 0; e_dout = 0; q.delete(); dtag = "R1";
      e_cb = 0; e_cg = 0; e_cr = 0; e_gi = 0; e_cf = 0;
      for (int s = 0; s < 24; s++) begin ep0[s] = 0; ep1[s] = 0; end
    end else begin
      e_dout = (md == 2 && frame_en) ? din : 1'b0;
      dtag = !frame_en ? "R2" : (md == 1 ? "R3" : (md == 2 ? "R4" : "R2"));
      if (pend) begin model_commit(); pend = 0; end
      if (!frame_en) md = 0;
      else if (hdr_valid) begin
        md = 1; rem = need_of(int'(hdr_cmd), int'(mux_en)); cq = int'(hdr_cmd); mq = int'(mux_en);
        q.delete();
      end else if (md == 1) begin
        q.push_back(din); rem--;
        if (rem == 0) begin md = 2; pend = 1; end
      end
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic check_all();
    vectors++;
    chk(dtag, "dout", int'(dout), int'(e_dout));
    chk("R5/R9", "cal_b", int'(cal_b), e_cb);
    chk("R5/R9", "cal_g", int'(cal_g), e_cg);
    chk("R5/R9", "cal_r", int'(cal_r), e_cr);
    chk("R6/R9", "gint", int'(gint), e_gi);
    chk("R6/R9", "cfg", int'(cfg), e_cf);
    for (int s = 0; s < 24; s++) begin
      chk("R7", "pwm0 slot", int'(pwm0[s*PW +: PW]), ep0[s]);
      chk("R8", "pwm1 slot", int'(pwm1[s*PW +: PW]), ep1[s]);
    end
  endtask

  task automatic cyc(bit fe, bit hv, int cmd, bit mx, bit d);
    @(negedge clk);
    check_all();
    frame_en = fe; hdr_valid = hv; hdr_cmd = 2'(cmd); mux_en = mx; din = d;
  endtask

  task automatic frame(int cmd, bit mx, bit pay[$], int tail, int cut);
    cyc(1, 1, cmd, mx, 0);
    for (int i = 0; i < pay.size() && i < cut; i++) cyc(1, 0, cmd, mx, pay[i]);
    if (cut >= pay.size())
      for (int i = 0; i < tail; i++) cyc(1, 0, cmd, mx, 1'($urandom));
    cyc(0, 0, 0, 0, 1'($urandom));
    cyc(0, 0, 0, 0, 1'($urandom));
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic rand_pay(int n, output bit p[$]);
    p.delete();
    for (int i = 0; i < n; i++) p.push_back(1'($urandom));
  endtask

  task automatic byte3(int a, int b, int c, output bit p[$]);
    p.delete();
    for (int i = 7; i >= 0; i--) p.push_back(1'(a >> i));
    for (int i = 7; i >= 0; i--) p.push_back(1'(b >> i));
    for (int i = 7; i >= 0; i--) p.push_back(1'(c >> i));
  endtask

  initial begin
    bit p[$];
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1);
    rst_n = 1'b1;
    // R2: idle noise, headers ignored while frame_en is low
    for (int i = 0; i < 12; i++) cyc(0, 1'($urandom), $urandom % 4, 0, 1'($urandom));
    // R5 and R4: colour trim with a long tail
    byte3(8'hA5, 8'h3C, 8'hF0, p); frame(1, 0, p, 40, 1000);
    // R6: intensity with one corrupted copy in each position
    byte3(8'h5A, 8'h5B, 8'hDA, p); frame(2, 0, p, 5, 1000);
    byte3(8'h81, 8'h7E, 8'h81, p); frame(3, 0, p, 0, 1000);
    byte3(8'h10, 8'h33, 8'h31, p); frame(3, 1, p, 9, 1000);
    // R7: non-multiplexed pulse-width load
    rand_pay(24 * PW, p); frame(0, 0, p, 20, 100000);
    // R8: multiplexed pulse-width load
    rand_pay(48 * PW, p); frame(0, 1, p, 20, 100000);
    // R2 and R9: abort halfway, nothing may change
    rand_pay(24 * PW, p); frame(0, 0, p, 0, 100);
    byte3(8'hFF, 8'hFF, 8'h00, p); frame(1, 0, p, 0, 23);
    // R10: restart in the middle of a share
    cyc(1, 1, 0, 1, 0);
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 1, 1'($urandom));
    byte3(8'h0F, 8'hE1, 8'h77, p); frame(1, 0, p, 12, 1000);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule